// File: doc/BRIEF.md
# Queue Interrupt Source and Pending Unit

This block turns per-queue status flags into two interrupt lines: one serving the lower half of the queues and one serving the upper half. Each lower queue carries a small programmable selector. The selector picks one of the queue's four status flags (empty, nearly empty, nearly full, full) and may invert it. Every upper queue is hard-wired to raise its interrupt when it stops being nearly empty.

A rising edge of a queue's selected condition latches a pending bit. A pending bit stays set until software writes a one to it. Each half has an enable register. An interrupt line is asserted when any pending bit in its half is also enabled, and the line comes from a flop. Software reaches the selectors, the enables and the pending bits over a simple write/read register port. The queue storage that produces the flags lies outside this block.

Top module: `qirq_unit`

## Requirements
- R1: The register map is: addresses 0..HALF/8-1 hold the source selectors, then low enable, high enable, low pending and high pending (0-3, 4, 5, 6, 7 for HALF=32). Lower queue q's 3-bit selector sits at address q/8, bits 4*(q mod 8)+2 down to 4*(q mod 8). The fourth bit of each slot is reserved and reads 0.
- R2: Selector bits 1:0 choose one flag of the lower queue: 0 empty, 1 nearly empty, 2 nearly full, 3 full. The flags of lower queue q arrive on `lo_flags[4q+3:4q]` with bit index equal to that code.
- R3: Selector bit 2 set inverts the chosen flag before edge detection.
- R4: Upper queue q uses the fixed condition "not nearly empty" (`hi_nempty[q]` low) and has no selector.
- R5: Each enable register holds one bit per queue of its half, queue q at bit q mod HALF, and reads back as written.
- R6: A pending bit sets on the clock edge after its condition goes from false to true. A condition that is held true sets nothing more.
- R7: Writing a pending register clears each bit written as 1 and leaves bits written as 0 unchanged.
- R8: When a rising edge and a clearing write hit the same pending bit in the same cycle, the bit ends set.
- R9: Each interrupt line is a flop loaded with the OR of pending AND enable for its half, so it follows a change in pending or enable one cycle later.
- R10: Synchronous active-low reset zeroes all selectors, enables, pending bits and both lines. A condition that is already true when reset ends does not set a pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lo_flags | input | 4*HALF | Four status flags per lower queue |
| hi_nempty | input | HALF | Nearly-empty flag per upper queue |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Read data for rd_addr (combinational) |
| irq_lo | output | 1 | Interrupt line for the lower half |
| irq_hi | output | 1 | Interrupt line for the upper half |

## Verification
The bench builds the block with its default parameters: HALF=32 and DATA_W=32. At these values all four selector registers exist and every slot of a 32-bit word is used, so the readback of reserved bits covers whole registers. The table walks all eight selector codes on one lower queue, covering both edges and held levels. Directed cases then cover the fixed upper condition, a clearing write that collides with a rising edge, and the one-cycle lag of the interrupt lines.

// File: rtl/qirq_pkg.sv
// Shared encodings for the queue interrupt unit.
package qirq_pkg;
    // Flag index inside a lower queue's 4-bit flag group.
    typedef enum logic [1:0] {
        FLG_EMPTY      = 2'd0,
        FLG_NEAR_EMPTY = 2'd1,
        FLG_NEAR_FULL  = 2'd2,
        FLG_FULL       = 2'd3
    } flag_sel_e;

    localparam int SEL_W     = 3;  // selector field width
    localparam int SLOT_W    = 4;  // slot width in a selector register
    localparam int SLOTS_PER = 8;  // slots per 32-bit selector register
    localparam int FLAGS_PER = 4;  // flags per lower queue
endpackage

// File: rtl/qirq_src_sel.sv
// Per-queue condition selection for the lower half.
// Assumes: src packs 3 bits per queue, bit 2 = invert, bits 1:0 = flag code;
// flags packs 4 bits per queue indexed by the flag code.
module qirq_src_sel
    import qirq_pkg::*;
#(
    parameter int HALF = 32
) (
    input  logic [FLAGS_PER*HALF-1:0] flags,
    input  logic [SEL_W*HALF-1:0]     src,
    output logic [HALF-1:0]           cond
);
    for (genvar q = 0; q < HALF; q++) begin : g_q
        logic [FLAGS_PER-1:0] grp;
        logic [SEL_W-1:0]     fld;
        // Pick the coded flag and apply the inversion bit.
        always_comb begin
            grp     = flags[FLAGS_PER*q +: FLAGS_PER];
            fld     = src[SEL_W*q +: SEL_W];
            cond[q] = grp[fld[1:0]] ^ fld[2];
        end
    end
endmodule

// File: rtl/qirq_pend.sv
// Edge detection, pending bits and the registered interrupt line of one half.
// Assumes: clr is a one-cycle write-one-to-clear mask; a rising edge in the
// same cycle as a clear leaves the bit set. The previous-condition flop keeps
// tracking during reset so that a level present at reset exit is not an edge.
module qirq_pend #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cond,
    input  logic [W-1:0] clr,
    input  logic [W-1:0] en,
    output logic [W-1:0] pend,
    output logic         irq
);
    logic [W-1:0] prev;
    logic [W-1:0] rise;

    // Remember last cycle's condition (also during reset).
    always_ff @(posedge clk) prev <= cond;

    // Rising edges of the condition.
    always_comb rise = cond & ~prev;

    // Pending bits: clear on write-one, set on edge, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | rise;
    end

    // Interrupt line registered from enabled pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(pend & en);
    end

    AST_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((pend & $past(rise)) == $past(rise))); // R6

    AST_CLR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend) & ~pend) & ~$past(clr)) == '0)); // R7

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & rise) != '0) |=> ((pend & $past(clr & rise)) == $past(clr & rise))); // R8
endmodule

// File: rtl/qirq_unit.sv
// Queue interrupt unit: lower-half selectors, upper-half fixed condition,
// per-half enable and pending registers and two registered interrupt lines.
// Assumes: HALF is a multiple of 8 and not above DATA_W; DATA_W is 32 so that
// eight 4-bit selector slots fill one register. Reads are combinational.
module qirq_unit
    import qirq_pkg::*;
#(
    parameter int HALF   = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = $clog2(HALF / SLOTS_PER + 4)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [FLAGS_PER*HALF-1:0] lo_flags,
    input  logic [HALF-1:0]           hi_nempty,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [DATA_W-1:0]         rd_data,
    output logic                      irq_lo,
    output logic                      irq_hi
);
    localparam int SRC_REGS = HALF / SLOTS_PER;
    localparam logic [ADDR_W-1:0] A_EN_LO   = ADDR_W'(SRC_REGS);
    localparam logic [ADDR_W-1:0] A_EN_HI   = ADDR_W'(SRC_REGS + 1);
    localparam logic [ADDR_W-1:0] A_PEND_LO = ADDR_W'(SRC_REGS + 2);
    localparam logic [ADDR_W-1:0] A_PEND_HI = ADDR_W'(SRC_REGS + 3);

    logic [SEL_W*HALF-1:0] src_q;
    logic [HALF-1:0]       en_lo, en_hi;
    logic [HALF-1:0]       pend_lo, pend_hi;
    logic [HALF-1:0]       cond_lo, cond_hi;
    logic [HALF-1:0]       clr_lo, clr_hi;

    // Selector registers: each queue takes its slot of the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
        end else if (wr_en) begin
            for (int q = 0; q < HALF; q++) begin
                if (wr_addr == ADDR_W'(q / SLOTS_PER))
                    src_q[SEL_W*q +: SEL_W] <= wr_data[SLOT_W*(q % SLOTS_PER) +: SEL_W];
            end
        end
    end

    // Enable registers, one per half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_lo <= '0;
            en_hi <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_EN_LO) en_lo <= wr_data[HALF-1:0];
            if (wr_addr == A_EN_HI) en_hi <= wr_data[HALF-1:0];
        end
    end

    // Write-one-to-clear masks for the pending registers.
    always_comb begin
        clr_lo = (wr_en && wr_addr == A_PEND_LO) ? wr_data[HALF-1:0] : '0;
        clr_hi = (wr_en && wr_addr == A_PEND_HI) ? wr_data[HALF-1:0] : '0;
    end

    // Upper queues: fixed "not nearly empty" condition.
    always_comb cond_hi = ~hi_nempty;

    qirq_src_sel #(.HALF(HALF)) u_sel (
        .flags (lo_flags),
        .src   (src_q),
        .cond  (cond_lo)
    );

    qirq_pend #(.W(HALF)) u_pend_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (cond_lo),
        .clr   (clr_lo),
        .en    (en_lo),
        .pend  (pend_lo),
        .irq   (irq_lo)
    );

    qirq_pend #(.W(HALF)) u_pend_hi (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (cond_hi),
        .clr   (clr_hi),
        .en    (en_hi),
        .pend  (pend_hi),
        .irq   (irq_hi)
    );

    // Read multiplexer; reserved slot bits and unused addresses read zero.
    always_comb begin
        rd_data = '0;
        if (rd_addr == A_EN_LO)        rd_data[HALF-1:0] = en_lo;
        else if (rd_addr == A_EN_HI)   rd_data[HALF-1:0] = en_hi;
        else if (rd_addr == A_PEND_LO) rd_data[HALF-1:0] = pend_lo;
        else if (rd_addr == A_PEND_HI) rd_data[HALF-1:0] = pend_hi;
        else begin
            for (int q = 0; q < HALF; q++) begin
                if (rd_addr == ADDR_W'(q / SLOTS_PER))
                    rd_data[SLOT_W*(q % SLOTS_PER) +: SEL_W] = src_q[SEL_W*q +: SEL_W];
            end
        end
    end

    AST_LO_LINE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |-> $past(en_lo != '0)); // R9

    AST_HI_LINE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> $past(en_hi != '0)); // R9
endmodule

// File: tb/qirq_unit_test.sv
`timescale 1ns/1ps
module qirq_unit_test;
    localparam int HALF = 32;
    localparam int DW   = 32;
    localparam int AW   = 3;
    localparam logic [AW-1:0] EN_LO = 3'd4, EN_HI = 3'd5, PD_LO = 3'd6, PD_HI = 3'd7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [4*HALF-1:0] lo_flags = '0;
    logic [HALF-1:0] hi_nempty = '1;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [DW-1:0]   wr_data = '0;
    logic [AW-1:0]   rd_addr = '0;
    logic [DW-1:0]   rd_data;
    logic            irq_lo, irq_hi;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;  // 125 MHz

    qirq_unit uut (
        .clk(clk), .rst_n(rst_n), .lo_flags(lo_flags), .hi_nempty(hi_nempty),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    // Vector: {selector[2:0], flags before[3:0], flags after[3:0], expect pending}
    localparam int NV = 12;
    localparam logic [11:0] VEC [NV] = '{
        {3'd0, 4'b0000, 4'b0001, 1'b1},
        {3'd0, 4'b0001, 4'b0001, 1'b0},
        {3'd1, 4'b0000, 4'b0010, 1'b1},
        {3'd2, 4'b0000, 4'b0100, 1'b1},
        {3'd3, 4'b0000, 4'b1000, 1'b1},
        {3'd3, 4'b0000, 4'b0001, 1'b0},
        {3'd4, 4'b0001, 4'b0000, 1'b1},
        {3'd4, 4'b0000, 4'b0001, 1'b0},
        {3'd5, 4'b0010, 4'b0000, 1'b1},
        {3'd6, 4'b0100, 4'b0000, 1'b1},
        {3'd7, 4'b1000, 4'b0000, 1'b1},
        {3'd7, 4'b1000, 4'b1001, 1'b0}
    };

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [DW-1:0] d;
        // Conditions already true while in reset: all lower empty, upper not nearly empty.
        for (int q = 0; q < HALF; q++) lo_flags[4*q] = 1'b1;
        hi_nempty = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R10: all registers zero, lines low, no pending from a level present at reset exit
        for (int a = 0; a < 8; a++) begin
            rd(AW'(a), d);
            check("R10", d, '0);
        end
        check("R10", {30'd0, irq_lo, irq_hi}, '0);

        lo_flags = '0;
        hi_nempty = '1;
        repeat (2) @(negedge clk);

        // R1: reserved slot bits read zero, selector slots read back
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, d); check("R1", d, 32'h7777_7777);
        wr(3'd2, 32'h0000_0000);
        wr(3'd3, 32'h0000_0500);
        rd(3'd3, d); check("R1", d, 32'h0000_0500);
        wr(3'd3, 32'h0);

        // R2 / R3 / R6: selector table on lower queue 9 (address 1, bits 6:4)
        for (int i = 0; i < NV; i++) begin
            logic [2:0] s;
            logic [3:0] fb, fa;
            logic       ex;
            {s, fb, fa, ex} = VEC[i];
            lo_flags[36 +: 4] = fb;
            wr(3'd1, DW'(s) << 4);
            repeat (2) @(negedge clk);
            wr(PD_LO, 32'hFFFF_FFFF);
            lo_flags[36 +: 4] = fa;
            @(negedge clk);
            rd(PD_LO, d);
            check(s[2] ? "R3" : "R2", d, DW'(ex) << 9);
        end
        lo_flags[36 +: 4] = 4'b0000;
        wr(3'd1, 32'h0);
        repeat (2) @(negedge clk);
        wr(PD_LO, 32'hFFFF_FFFF);

        // R4: upper queue 40 (bit 8) sets pending when it leaves nearly empty
        hi_nempty[8] = 1'b0;
        @(negedge clk);
        rd(PD_HI, d); check("R4", d, 32'h0000_0100);
        // R6: held condition sets nothing more after clear
        wr(PD_HI, 32'h0000_0100);
        repeat (2) @(negedge clk);
        rd(PD_HI, d); check("R6", d, 32'h0);
        hi_nempty[8] = 1'b1;  // R4: returning to nearly empty sets nothing
        repeat (2) @(negedge clk);
        rd(PD_HI, d); check("R4", d, 32'h0);
        hi_nempty[8] = 1'b0;
        @(negedge clk);

        // R7: writing zeros leaves the bit, writing one clears it
        wr(PD_HI, 32'h0);
        rd(PD_HI, d); check("R7", d, 32'h0000_0100);
        wr(PD_HI, 32'h0000_0100);
        rd(PD_HI, d); check("R7", d, 32'h0);

        // R5: enable registers read back
        wr(EN_LO, 32'hA5A5_0001);
        rd(EN_LO, d); check("R5", d, 32'hA5A5_0001);
        wr(EN_LO, 32'h0);
        rd(EN_LO, d); check("R5", d, 32'h0);

        // R8: rising edge of upper queue 3 together with a clearing write
        @(negedge clk);
        hi_nempty[3] = 1'b0;
        wr_en = 1'b1; wr_addr = PD_HI; wr_data = 32'h0000_0008;
        @(negedge clk);
        wr_en = 1'b0;
        rd(PD_HI, d); check("R8", d, 32'h0000_0008);

        // R9: line lags the enable write by one cycle
        check("R9", {31'd0, irq_hi}, 32'd0);
        wr(EN_HI, 32'h0000_0008);
        check("R9", {31'd0, irq_hi}, 32'd0);
        @(negedge clk);
        check("R9", {31'd0, irq_hi}, 32'd1);
        check("R9", {31'd0, irq_lo}, 32'd0);
        wr(PD_HI, 32'h0000_0008);
        check("R9", {31'd0, irq_hi}, 32'd1);
        @(negedge clk);
        check("R9", {31'd0, irq_hi}, 32'd0);

        // R9: lower line from queue 0 with selector "full"
        wr(EN_LO, 32'h0000_0001);
        wr(3'd0, 32'h0000_0003);
        lo_flags[3] = 1'b1;
        @(negedge clk);
        check("R9", {31'd0, irq_lo}, 32'd0);
        @(negedge clk);
        check("R9", {31'd0, irq_lo}, 32'd1);

        summary();
    end
endmodule